// File: doc/BRIEF.md
# Sequential Divider With Cycle Accounting

This unit divides a 32-bit dividend by a 16-bit divisor over several clocks, treating both operands either as unsigned or as two's complement numbers. A restoring division retires one quotient bit per clock. The packed answer holds the remainder in the upper half-word and the quotient in the lower half-word. Alongside the answer the unit reports four condition flags (negative, zero, overflow, carry), a write-enable that says whether the destination should be updated, a divide-by-zero exception request, and the number of machine cycles that the operation is defined to cost under a fixed, data-dependent timing model.

An operation is offered on the input side with a valid/ready handshake. `in_ready` is high only while the unit is idle. A request offered while it is low is not taken and has no effect: the requester must hold it until `in_ready` is high. The output side has no back-pressure. `out_done` pulses for one clock, and the result, flags and cycle count then hold until the next completion. A zero divisor or an overflow is detected when the request is accepted, so these cases complete on the next clock. A normal division completes 18 clocks after acceptance.

Top module: `seqdiv_cyc`

## Requirements
- R1: Unsigned mode (`in_signed`=0) with a nonzero divisor and a quotient of at most 65535: `out_write`=1 and `out_result` = {remainder[15:0], quotient[15:0]}, with the remainder in bits 31:16.
- R2: Signed mode (`in_signed`=1): the quotient is negative exactly when the operand signs differ. The remainder carries the sign of the dividend. Both are packed as in R1.
- R3: A zero divisor sets `out_exc`=1 and `out_write`=0 and leaves `out_result` unchanged. It clears N, Z, V and C, and reports `out_cycles`=0.
- R4: Unsigned overflow (quotient > 65535) sets V=1 and N=1, clears Z and C, reports `out_cycles`=6 and sets `out_write`=0. `out_result` is left unchanged.
- R5: Signed overflow (magnitude of the quotient > 32767) sets V=1 and clears C. N and Z keep their previous values. It reports `out_cycles`=12 and sets `out_write`=0. `out_result` is left unchanged.
- R6: On success C=0 and V=0. Z=1 exactly when the 16-bit quotient is zero, and N equals bit 15 of the quotient.
- R7: The unsigned success cycle count starts at 12. It runs 15 iterations on a working copy of the dividend against the divisor shifted left by 16. If bit 31 is set, the iteration shifts left and subtracts, costing 4. Otherwise it shifts left, then subtracts if the value is not below the shifted divisor (costing 6); if it is below, nothing is subtracted (costing 8).
- R8: The signed success cycle count is 12 + 104, plus 2 if the dividend is negative, plus 2 for each zero bit among bits 15..1 of the unsigned quotient magnitude. It then adds 2 more if the divisor is negative, or otherwise 4 more if the dividend is negative.
- R9: `in_valid` is ignored while `in_ready`=0. `out_done` lasts exactly one clock. `out_result` does not change while a division is running.
- R10: After reset `in_ready`=1, and `out_done`, `out_result` and `out_cycles` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle; a request is taken on a clock edge when both are high |
| in_signed | input | 1 | 1 = two's complement operands |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 16 | Divisor |
| out_done | output | 1 | One-clock completion pulse |
| out_write | output | 1 | With out_done: destination should be written |
| out_result | output | 32 | {remainder, quotient} |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_exc | output | 1 | With out_done: divide-by-zero exception request |
| out_cycles | output | 10 | Modelled machine-cycle cost |

## Verification
The bench targets the overflow thresholds from both sides: a quotient of exactly 65535 against 65536 in unsigned mode, and 32767 against 32768 and -32768 in signed mode. A design with an off-by-one threshold would write a truncated quotient, or would refuse a legal one. All four sign combinations are run, so a remainder that takes the divisor's sign or a wrongly negated quotient shows up in the packed word. Signed overflow follows an operation with known N and Z, which exposes a design that clears those flags instead of keeping them. A second request is offered while a division is running; a unit that accepted it would corrupt the division in flight. The cycle counts are compared against an independent model of both cost rules, which catches a wrong per-iteration charge or a missed tail adjustment.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  localparam int unsigned CYC_W          = 10;
  localparam int unsigned COST_BASE      = 12;
  localparam int unsigned COST_MSB_SET   = 4;
  localparam int unsigned COST_SUB_OK    = 6;
  localparam int unsigned COST_NO_SUB    = 8;
  localparam int unsigned COST_U_OVF     = 6;
  localparam int unsigned COST_S_OVF     = 12;
  localparam int unsigned COST_S_FIXED   = 104;
  localparam int unsigned COST_PER_ZERO  = 2;
  localparam int unsigned COST_NEG_DVD   = 2;
  localparam int unsigned COST_TAIL_DVS  = 2;
  localparam int unsigned COST_TAIL_DVD  = 4;

endpackage

// File: rtl/seqdiv_prep.sv
module seqdiv_prep #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input  logic [DW-1:0] dividend,
  input  logic [SW-1:0] divisor,
  input  logic          signed_mode,
  output logic [DW-1:0] mag_a,
  output logic [SW-1:0] mag_d,
  output logic          a_neg,
  output logic          d_neg,
  output logic          div_zero,
  output logic          too_big
);
  localparam int unsigned XW = ((DW > SW) ? DW : SW) + 1;

  logic [XW-1:0] hi_u, hi_s, dz;

  always_comb begin
    a_neg    = signed_mode & dividend[DW-1];
    d_neg    = signed_mode & divisor[SW-1];
    mag_a    = a_neg ? (~dividend + 1'b1) : dividend;
    mag_d    = d_neg ? (~divisor + 1'b1) : divisor;
    div_zero = (divisor == '0);
    // quotient overflows when the dividend's high part reaches the divisor
    hi_u     = XW'(mag_a[DW-1:SW]);
    hi_s     = XW'(mag_a[DW-1:SW-1]);
    dz       = XW'(mag_d);
    too_big  = signed_mode ? (hi_s >= dz) : (hi_u >= dz);
  end
endmodule

// File: rtl/seqdiv_step.sv
module seqdiv_step #(
  parameter int unsigned SW = 16
) (
  input  logic [SW-1:0] rem_in,
  input  logic          bit_in,
  input  logic [SW-1:0] dvs,
  output logic [SW-1:0] rem_out,
  output logic          q_bit
);
  logic [SW:0] trial;
  logic [SW:0] diff;

  always_comb begin
    trial   = {rem_in, bit_in};
    diff    = trial - {1'b0, dvs};
    q_bit   = (trial >= {1'b0, dvs});
    rem_out = q_bit ? diff[SW-1:0] : trial[SW-1:0];
  end
endmodule

// File: rtl/seqdiv_ucost_step.sv
module seqdiv_ucost_step
  import seqdiv_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input  logic [DW-1:0]    t_in,
  input  logic [SW-1:0]    dvs,
  output logic [DW-1:0]    t_out,
  output logic [CYC_W-1:0] inc
);
  logic [DW-1:0] shifted_dvs;
  logic [DW-1:0] t2;

  always_comb begin
    shifted_dvs = DW'(dvs) << (DW - SW);
    t2          = t_in << 1;
    if (t_in[DW-1]) begin
      t_out = t2 - shifted_dvs;
      inc   = CYC_W'(COST_MSB_SET);
    end else if (t2 >= shifted_dvs) begin
      t_out = t2 - shifted_dvs;
      inc   = CYC_W'(COST_SUB_OK);
    end else begin
      t_out = t2;
      inc   = CYC_W'(COST_NO_SUB);
    end
  end
endmodule

// File: rtl/seqdiv_scost.sv
module seqdiv_scost
  import seqdiv_pkg::*;
#(
  parameter int unsigned SW = 16
) (
  input  logic [SW-1:0]    q_mag,
  input  logic             a_neg,
  input  logic             d_neg,
  output logic [CYC_W-1:0] cost
);
  logic [CYC_W-1:0] zeros;

  always_comb begin
    zeros = '0;
    for (int i = 1; i < int'(SW); i++) begin
      zeros = zeros + CYC_W'(!q_mag[i]);
    end
    cost = CYC_W'(COST_BASE + COST_S_FIXED) + CYC_W'(COST_PER_ZERO) * zeros;
    if (a_neg) cost = cost + CYC_W'(COST_NEG_DVD);
    if (d_neg)      cost = cost + CYC_W'(COST_TAIL_DVS);
    else if (a_neg) cost = cost + CYC_W'(COST_TAIL_DVD);
  end
endmodule

// File: rtl/seqdiv_cyc.sv
module seqdiv_cyc
  import seqdiv_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_signed,
  input  logic [DW-1:0]    in_dividend,
  input  logic [SW-1:0]    in_divisor,
  output logic             out_done,
  output logic             out_write,
  output logic [DW-1:0]    out_result,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_c,
  output logic             out_exc,
  output logic [CYC_W-1:0] out_cycles
);
  localparam int unsigned CNT_W    = $clog2(SW);
  localparam int unsigned COST_ITS = SW - 1;

  div_state_e        state;
  logic [CNT_W-1:0]  step_cnt;
  logic [SW-1:0]     rem_q, low_q, dvs_q;
  logic [DW-1:0]     tmod_q;
  logic [CYC_W-1:0]  ucost_q;
  logic              sgn_q, aneg_q, dneg_q;

  logic [DW-1:0]     mag_a;
  logic [SW-1:0]     mag_d;
  logic              a_neg, d_neg, div_zero, too_big;
  logic [SW-1:0]     rem_nx;
  logic              q_bit;
  logic [DW-1:0]     tmod_nx;
  logic [CYC_W-1:0]  ucost_inc;
  logic [CYC_W-1:0]  scost;
  logic [SW-1:0]     q_final, r_final;
  logic              accept;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  seqdiv_prep #(.DW(DW), .SW(SW)) prep_i (
    .dividend(in_dividend), .divisor(in_divisor), .signed_mode(in_signed),
    .mag_a(mag_a), .mag_d(mag_d), .a_neg(a_neg), .d_neg(d_neg),
    .div_zero(div_zero), .too_big(too_big)
  );

  seqdiv_step #(.SW(SW)) step_i (
    .rem_in(rem_q), .bit_in(low_q[SW-1]), .dvs(dvs_q),
    .rem_out(rem_nx), .q_bit(q_bit)
  );

  seqdiv_ucost_step #(.DW(DW), .SW(SW)) ucost_i (
    .t_in(tmod_q), .dvs(dvs_q), .t_out(tmod_nx), .inc(ucost_inc)
  );

  seqdiv_scost #(.SW(SW)) scost_i (
    .q_mag(low_q), .a_neg(aneg_q), .d_neg(dneg_q), .cost(scost)
  );

  always_comb begin
    q_final = (aneg_q ^ dneg_q) ? (~low_q + 1'b1) : low_q;
    r_final = aneg_q ? (~rem_q + 1'b1) : rem_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step_cnt   <= '0;
      rem_q      <= '0;
      low_q      <= '0;
      dvs_q      <= '0;
      tmod_q     <= '0;
      ucost_q    <= '0;
      sgn_q      <= 1'b0;
      aneg_q     <= 1'b0;
      dneg_q     <= 1'b0;
      out_done   <= 1'b0;
      out_write  <= 1'b0;
      out_exc    <= 1'b0;
      out_result <= '0;
      out_n      <= 1'b0;
      out_z      <= 1'b0;
      out_v      <= 1'b0;
      out_c      <= 1'b0;
      out_cycles <= '0;
    end else begin
      out_done  <= 1'b0;
      out_write <= 1'b0;
      out_exc   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (div_zero) begin
              out_done   <= 1'b1;
              out_exc    <= 1'b1;
              out_n      <= 1'b0;
              out_z      <= 1'b0;
              out_v      <= 1'b0;
              out_c      <= 1'b0;
              out_cycles <= '0;
            end else if (too_big) begin
              out_done <= 1'b1;
              out_v    <= 1'b1;
              out_c    <= 1'b0;
              if (in_signed) begin
                out_cycles <= CYC_W'(COST_S_OVF);
              end else begin
                out_n      <= 1'b1;
                out_z      <= 1'b0;
                out_cycles <= CYC_W'(COST_U_OVF);
              end
            end else begin
              state    <= ST_RUN;
              step_cnt <= '0;
              rem_q    <= SW'(mag_a[DW-1:SW]);
              low_q    <= mag_a[SW-1:0];
              dvs_q    <= mag_d;
              tmod_q   <= in_dividend;
              ucost_q  <= CYC_W'(COST_BASE);
              sgn_q    <= in_signed;
              aneg_q   <= a_neg;
              dneg_q   <= d_neg;
            end
          end
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          low_q <= {low_q[SW-2:0], q_bit};
          if (32'(step_cnt) < COST_ITS) begin
            tmod_q  <= tmod_nx;
            ucost_q <= ucost_q + ucost_inc;
          end
          step_cnt <= step_cnt + 1'b1;
          if (32'(step_cnt) == SW - 1) state <= ST_FIN;
        end
        ST_FIN: begin
          out_done   <= 1'b1;
          out_write  <= 1'b1;
          out_result <= {r_final, q_final};
          out_n      <= q_final[SW-1];
          out_z      <= (q_final == '0);
          out_v      <= 1'b0;
          out_c      <= 1'b0;
          out_cycles <= sgn_q ? scost : ucost_q;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done); // R9
  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> (out_done && !out_write && !out_v)); // R3
  AST_KEEP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_write) |-> (out_result == $past(out_result))); // R4
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !out_c); // R6
  AST_OVF_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_v) |-> (!out_write && (out_cycles == 10'd6 || out_cycles == 10'd12))); // R5
  AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> $stable(out_result)); // R9
endmodule

// File: tb/seqdiv_cyc_tb.sv
module seqdiv_cyc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_dividend = '0;
  logic [15:0] in_divisor = '0;
  logic        out_done, out_write, out_n, out_z, out_v, out_c, out_exc;
  logic [31:0] out_result;
  logic [9:0]  out_cycles;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic        wr;
    logic [31:0] res;
    logic        n, z, v, c, exc;
    logic [9:0]  cyc;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] prev_res = '0;
  logic        prev_n = 1'b0, prev_z = 1'b0;

  always #2 clk = ~clk;

  seqdiv_cyc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_done(out_done), .out_write(out_write), .out_result(out_result),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c),
    .out_exc(out_exc), .out_cycles(out_cycles)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ucost_model(input logic [31:0] a, input logic [15:0] d);
    logic [31:0] t = a;
    logic [31:0] ds = {d, 16'h0};
    int c = 12;
    for (int i = 0; i < 15; i++) begin
      if (t[31]) begin t = (t << 1) - ds; c += 4; end
      else begin
        t = t << 1;
        if (t >= ds) begin t = t - ds; c += 6; end
        else c += 8;
      end
    end
    return 10'(c);
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [15:0] d, input logic s);
    exp_t e;
    longint sa, sd, ma, md, q, r, qs;
    e = '0;
    e.res = prev_res;
    if (d == 0) begin
      e.exc = 1'b1;
      return e;
    end
    sa = s ? longint'($signed(a)) : longint'(a);
    sd = s ? longint'($signed(d)) : longint'(d);
    ma = (sa < 0) ? -sa : sa;
    md = (sd < 0) ? -sd : sd;
    q  = ma / md;
    if (!s && q > 65535) begin
      e.v = 1; e.n = 1; e.z = 0; e.cyc = 10'd6;
      return e;
    end
    if (s && q > 32767) begin
      e.v = 1; e.n = prev_n; e.z = prev_z; e.cyc = 10'd12;
      return e;
    end
    r  = sa % sd;
    qs = ((sa < 0) != (sd < 0)) ? -q : q;
    e.wr  = 1'b1;
    e.res = {16'(r), 16'(qs)};
    e.z   = (16'(qs) == 16'h0);
    e.n   = e.res[15];
    if (!s) e.cyc = ucost_model(a, d);
    else begin
      int c = 116;
      for (int i = 1; i < 16; i++) if (!q[i]) c += 2;
      if (sa < 0) c += 2;
      if (sd < 0) c += 2;
      else if (sa < 0) c += 4;
      e.cyc = 10'(c);
    end
    return e;
  endfunction

  // driver: pushes the expectation, offers the request, and for long
  // operations offers a stray request while the unit is busy (R9)
  task automatic run_op(input logic [31:0] a, input logic [15:0] d, input logic s);
    exp_t e;
    e = model(a, d, s);
    exp_q.push_back(e);
    prev_res = e.res; prev_n = e.n; prev_z = e.z;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_signed = s; in_dividend = a; in_divisor = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (e.wr) begin
      check("R9 busy ready low", {63'h0, in_ready}, 64'h0);
      @(negedge clk);
      in_valid = 1'b1; in_dividend = ~a; in_divisor = 16'h0; in_signed = ~s;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    while (!out_done) @(negedge clk);
    @(negedge clk);
    check("R9 done one cycle", {63'h0, out_done}, 64'h0);
  endtask

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_done) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", 64'h1, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.exc ? "R3 write" : (e.v ? "R4/R5 write" : "R1 write"),
              {63'h0, out_write}, {63'h0, e.wr});
        check(e.wr ? "R1/R2 result" : "R3/R4/R5 result held",
              {32'h0, out_result}, {32'h0, e.res});
        check("R3 exception", {63'h0, out_exc}, {63'h0, e.exc});
        check("R6 flags nzvc", {60'h0, out_n, out_z, out_v, out_c},
              {60'h0, e.n, e.z, e.v, e.c});
        check("R7/R8 cycles", {54'h0, out_cycles}, {54'h0, e.cyc});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ready", {63'h0, in_ready}, 64'h1);
    check("R10 done", {63'h0, out_done}, 64'h0);
    check("R10 result", {32'h0, out_result}, 64'h0);
    check("R10 cycles", {54'h0, out_cycles}, 64'h0);

    run_op(32'd100, 16'd7, 1'b0);            // R1 R7
    run_op(32'd0, 16'd5, 1'b0);              // R6 zero quotient
    run_op(32'hFFFE_FFFF, 16'hFFFF, 1'b0);   // R1 quotient 65535
    run_op(32'h0001_0000, 16'd1, 1'b0);      // R4 quotient 65536
    run_op(32'd55, 16'd0, 1'b0);             // R3 unsigned zero divisor
    run_op(32'hFFFF_FF9C, 16'd7, 1'b1);      // R2 -100/7
    run_op(32'd100, 16'hFFF9, 1'b1);         // R2 100/-7
    run_op(32'hFFFF_FF9C, 16'hFFF9, 1'b1);   // R2 -100/-7
    run_op(32'h0000_7FFF, 16'd1, 1'b1);      // R5 boundary, legal
    run_op(32'h0000_8000, 16'd1, 1'b1);      // R5 overflow, N Z held
    run_op(32'hFFFF_8000, 16'd1, 1'b1);      // R5 -32768 overflows
    run_op(32'd0, 16'd3, 1'b1);              // R6 Z set then
    run_op(32'h0001_0000, 16'd1, 1'b1);      // R5 N Z held from Z=1
    run_op(32'hFFFF_FFFF, 16'd0, 1'b1);      // R3 signed zero divisor
    run_op(32'h8000_0000, 16'hFFFF, 1'b1);   // R5 most negative dividend
    for (int i = 0; i < 40; i++) begin       // R1 R2 R7 R8 mixed
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op(lf >> (i % 17), (lf[15:0] == 0) ? 16'h3 : lf[23:8], i[0]);
    end
    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule